// File: doc/BRIEF.md
# Segmented Pipelined-Wakeup Issue Queue

This block holds instructions that wait for their source operands and tells a separate select unit which of them may issue. Its slots are grouped into segments of eight. A result tag presented on one of the two broadcast lanes is not compared against every slot in the same cycle. The comparison reaches the head segment in the cycle the tag is presented, the next segment one clock later, and so on down the queue. This keeps the wakeup path short at the cost of later wakeup for the younger slots.

Each slot holds two source tags with their ready flags, a destination tag and a valid flag. The select unit drives a per-slot issue strobe that removes entries. The surviving entries drift toward the head one slot per cycle, which keeps the oldest instructions at the front. A slot that crosses a segment boundary while moving is compared against the delayed tags of both segments in that cycle, so it cannot miss a tag that is still travelling. Up to two new instructions per cycle enter directly behind the youngest entry. A full flag refuses new instructions when fewer than two slots remain behind the youngest entry.

The number of segments (two to ten), the segment size and the tag width are parameters.

Top module: `segIssueQueue`

## Requirements
- R1: A synchronous active-high reset clears every valid flag and every delayed broadcast tag, so `validVec`, `readyVec` and `full` read zero and a tag presented before reset never wakes a later entry.
- R2: `readyVec[i]` is 1 exactly when slot i is valid and both of its source ready flags are set; a slot with only one source woken stays 0.
- R3: A tag presented with its lane valid in cycle t is compared against segment k (slots k*SEG_SIZE to k*SEG_SIZE+SEG_SIZE-1) in cycle t+k; a matching slot shows its new ready flag after the clock edge that ends cycle t+k.
- R4: Two broadcast lanes exist (lane n uses `bcValid[n]` and `bcTag[n*TAG_W +: TAG_W]`); a match on either lane sets the ready flag of either source.
- R5: A 1 on `issueMask[i]` removes the entry in slot i at that clock edge; the number of valid entries after the edge equals the entries that survived removal plus the instructions accepted.
- R6: Every surviving entry with an empty slot anywhere in front of it moves forward by exactly one slot per cycle; entries with no gap ahead stay put, and relative order never changes.
- R7: An entry that moves from the first slot of segment k into the last slot of segment k-1 is compared in that cycle against the delayed tags of both segments, so a tag in transit between them still wakes it.
- R8: Accepted instructions land in consecutive slots directly behind the youngest entry left after that cycle's removal and compaction (slot 0 if none); lane 0 takes the first slot when valid, and a lone lane 1 instruction takes that first slot.
- R9: `full` is 1 when the highest valid slot index is at least DEPTH-2; in such a cycle both insertion lanes are dropped.
- R10: An instruction entering the queue is compared against the tags presented that cycle and every delayed tag still in flight, in addition to the ready flags supplied with it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| insValid | input | 2 | Per-lane insertion request |
| insSrcA | input | 2*TAG_W | First source tag for each lane |
| insSrcB | input | 2*TAG_W | Second source tag for each lane |
| insRdyA | input | 2 | First source already available, per lane |
| insRdyB | input | 2 | Second source already available, per lane |
| insDst | input | 2*TAG_W | Destination tag for each lane |
| bcValid | input | 2 | Broadcast lane valid |
| bcTag | input | 2*TAG_W | Broadcast result tags |
| issueMask | input | DEPTH | Per-slot removal strobe from select |
| readyVec | output | DEPTH | Per-slot ready-to-issue vector |
| validVec | output | DEPTH | Per-slot occupancy |
| dstFlat | output | DEPTH*TAG_W | Destination tag of every slot, slot i at bits i*TAG_W |
| full | output | 1 | Insertion is refused this cycle |

## Verification
The bench goes after the wakeup timing per segment: a design that compares all slots at once, or that is one cycle late, shows the second segment ready a cycle early or a cycle late. The sharpest case is an entry leaving the first slot of segment one in the same cycle a tag is presented. A design that checks only the old segment loses that tag for good, and the entry never becomes ready. Two gaps removed in one cycle must close over two cycles while an insertion lands behind the youngest entry. A queue that fills holes out of order or inserts into the gap shows the wrong destination tags. The full boundary, a stale tag across reset and insertion against an in-flight tag are each probed, and a long random run is compared slot by slot against an arithmetic model.

// File: rtl/iqPkg.sv
`timescale 1ns/1ps
package iqPkg;
  // strobes from control to datapath for the two insertion lanes
  typedef struct packed {
    logic take0;
    logic take1;
  } iqStrobeT;
endpackage

// File: rtl/iqCtl.sv
`timescale 1ns/1ps
module iqCtl
  import iqPkg::*;
#(
  parameter int DEPTH = 32,
  parameter int POS_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DEPTH-1:0] validVec,
  input  logic [DEPTH-1:0] issueMask,
  input  logic [1:0]       insValid,
  output iqStrobeT         strb,
  output logic [DEPTH-1:0] liveVec,
  output logic [DEPTH-1:0] moveMask,
  output logic [POS_W-1:0] pos0,
  output logic [POS_W-1:0] pos1,
  output logic             full
);

  int   liveHi;
  logic liveHiMoves;
  int   validHi;
  int   tailSlot;
  logic seenHole;

  always_comb begin
    liveVec     = validVec & ~issueMask;
    seenHole    = 1'b0;
    liveHi      = -1;
    liveHiMoves = 1'b0;
    validHi     = -1;
    for (int i = 0; i < DEPTH; i++) begin
      moveMask[i] = liveVec[i] & seenHole;
      if (!liveVec[i]) seenHole = 1'b1;
      if (liveVec[i]) begin
        liveHi      = i;
        liveHiMoves = seenHole;
      end
      if (validVec[i]) validHi = i;
    end
    // first free slot behind the youngest entry after this cycle's compaction
    if (liveHi < 0)       tailSlot = 0;
    else if (liveHiMoves) tailSlot = liveHi;
    else                  tailSlot = liveHi + 1;
    full       = (validHi >= DEPTH - 2);
    strb.take0 = insValid[0] & ~full;
    strb.take1 = insValid[1] & ~full;
    pos0       = POS_W'(tailSlot);
    pos1       = POS_W'(tailSlot + (strb.take0 ? 1 : 0));
  end

  // R5: occupancy after the edge is survivors plus accepted instructions
  p_count_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $countones(validVec) ==
             $past($countones(liveVec)) + $past(32'(strb.take0)) + $past(32'(strb.take1)));

  // R9: a full queue never grows
  p_full_blocks_r9: assert property (@(posedge clk) disable iff (rst)
    (full && (insValid != 2'b00)) |=> $countones(validVec) <= $past($countones(validVec)));

  // R6: an entry only steps into a slot that is empty or being vacated
  for (genvar g = 1; g < DEPTH; g++) begin : gMoveChk
    p_move_dest_free_r6: assert property (@(posedge clk) disable iff (rst)
      moveMask[g] |-> (!liveVec[g-1] || moveMask[g-1]));
  end

endmodule

// File: rtl/iqData.sv
`timescale 1ns/1ps
module iqData
  import iqPkg::*;
#(
  parameter int NUM_SEGS = 4,
  parameter int SEG_SIZE = 8,
  parameter int TAG_W    = 7,
  parameter int DEPTH    = NUM_SEGS * SEG_SIZE,
  parameter int POS_W    = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0]             bcValid,
  input  logic [2*TAG_W-1:0]     bcTag,
  input  logic [2*TAG_W-1:0]     insSrcA,
  input  logic [2*TAG_W-1:0]     insSrcB,
  input  logic [1:0]             insRdyA,
  input  logic [1:0]             insRdyB,
  input  logic [2*TAG_W-1:0]     insDst,
  input  iqStrobeT               strb,
  input  logic [DEPTH-1:0]       liveVec,
  input  logic [DEPTH-1:0]       moveMask,
  input  logic [POS_W-1:0]       pos0,
  input  logic [POS_W-1:0]       pos1,
  output logic [DEPTH-1:0]       validVec,
  output logic [DEPTH-1:0]       readyVec,
  output logic [DEPTH*TAG_W-1:0] dstFlat
);

  // slot storage
  logic [DEPTH-1:0] vld, rdyA, rdyB;
  logic [TAG_W-1:0] tagA [DEPTH];
  logic [TAG_W-1:0] tagB [DEPTH];
  logic [TAG_W-1:0] tagD [DEPTH];

  // delayed broadcast stages; stage 0 is the live input
  logic [1:0]       pipeV [NUM_SEGS-1];
  logic [TAG_W-1:0] pipeT [NUM_SEGS-1][2];
  logic [1:0]       stgV  [NUM_SEGS];
  logic [TAG_W-1:0] stgT  [NUM_SEGS][2];

  always_comb begin
    stgV[0]    = bcValid;
    stgT[0][0] = bcTag[TAG_W-1:0];
    stgT[0][1] = bcTag[2*TAG_W-1:TAG_W];
    for (int k = 1; k < NUM_SEGS; k++) begin
      stgV[k]    = pipeV[k-1];
      stgT[k][0] = pipeT[k-1][0];
      stgT[k][1] = pipeT[k-1][1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NUM_SEGS - 1; k++) pipeV[k] <= 2'b00;
    end else begin
      pipeV[0] <= bcValid;
      for (int k = 1; k < NUM_SEGS - 1; k++) pipeV[k] <= pipeV[k-1];
    end
  end

  always_ff @(posedge clk) begin
    pipeT[0][0] <= bcTag[TAG_W-1:0];
    pipeT[0][1] <= bcTag[2*TAG_W-1:TAG_W];
    for (int k = 1; k < NUM_SEGS - 1; k++) begin
      pipeT[k][0] <= pipeT[k-1][0];
      pipeT[k][1] <= pipeT[k-1][1];
    end
  end

  // wakeup of resident slots: own segment stage, plus the next segment's
  // stage when the slot crosses a boundary this cycle
  logic [DEPTH-1:0] wakeA, wakeB;
  int   segIdx, prevIdx;
  logic crossing;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      segIdx   = i / SEG_SIZE;
      prevIdx  = (segIdx > 0) ? segIdx - 1 : 0;
      crossing = (i % SEG_SIZE == 0) && (i > 0) && moveMask[i];
      wakeA[i] = rdyA[i];
      wakeB[i] = rdyB[i];
      for (int l = 0; l < 2; l++) begin
        if (stgV[segIdx][l]) begin
          if (stgT[segIdx][l] == tagA[i]) wakeA[i] = 1'b1;
          if (stgT[segIdx][l] == tagB[i]) wakeB[i] = 1'b1;
        end
        if (crossing && stgV[prevIdx][l]) begin
          if (stgT[prevIdx][l] == tagA[i]) wakeA[i] = 1'b1;
          if (stgT[prevIdx][l] == tagB[i]) wakeB[i] = 1'b1;
        end
      end
    end
  end

  // wakeup of entering instructions against every stage
  logic [1:0] insWakeA, insWakeB;

  always_comb begin
    for (int n = 0; n < 2; n++) begin
      insWakeA[n] = insRdyA[n];
      insWakeB[n] = insRdyB[n];
      for (int k = 0; k < NUM_SEGS; k++) begin
        for (int l = 0; l < 2; l++) begin
          if (stgV[k][l] && stgT[k][l] == insSrcA[n*TAG_W +: TAG_W]) insWakeA[n] = 1'b1;
          if (stgV[k][l] && stgT[k][l] == insSrcB[n*TAG_W +: TAG_W]) insWakeB[n] = 1'b1;
        end
      end
    end
  end

  // next state: pull from behind, keep, or insert
  logic [DEPTH-1:0] nV, nRa, nRb;
  logic [TAG_W-1:0] nA [DEPTH];
  logic [TAG_W-1:0] nB [DEPTH];
  logic [TAG_W-1:0] nD [DEPTH];
  logic insClash;
  int   upIdx;
  logic moveIn, keepHere, hit0, hit1;

  always_comb begin
    insClash = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      upIdx    = (i + 1 < DEPTH) ? i + 1 : i;
      moveIn   = (i + 1 < DEPTH) && moveMask[upIdx];
      keepHere = liveVec[i] && !moveMask[i];
      hit0     = strb.take0 && (pos0 == POS_W'(i));
      hit1     = strb.take1 && (pos1 == POS_W'(i));
      nV[i] = 1'b0; nRa[i] = 1'b0; nRb[i] = 1'b0;
      nA[i] = '0;   nB[i] = '0;    nD[i] = '0;
      if (moveIn) begin
        nV[i] = 1'b1; nRa[i] = wakeA[upIdx]; nRb[i] = wakeB[upIdx];
        nA[i] = tagA[upIdx]; nB[i] = tagB[upIdx]; nD[i] = tagD[upIdx];
      end else if (keepHere) begin
        nV[i] = 1'b1; nRa[i] = wakeA[i]; nRb[i] = wakeB[i];
        nA[i] = tagA[i]; nB[i] = tagB[i]; nD[i] = tagD[i];
      end else if (hit0) begin
        nV[i] = 1'b1; nRa[i] = insWakeA[0]; nRb[i] = insWakeB[0];
        nA[i] = insSrcA[TAG_W-1:0]; nB[i] = insSrcB[TAG_W-1:0]; nD[i] = insDst[TAG_W-1:0];
      end else if (hit1) begin
        nV[i] = 1'b1; nRa[i] = insWakeA[1]; nRb[i] = insWakeB[1];
        nA[i] = insSrcA[2*TAG_W-1:TAG_W]; nB[i] = insSrcB[2*TAG_W-1:TAG_W];
        nD[i] = insDst[2*TAG_W-1:TAG_W];
      end
      if ((hit0 || hit1) && (moveIn || keepHere)) insClash = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else     vld <= nV;
  end

  always_ff @(posedge clk) begin
    rdyA <= nRa;
    rdyB <= nRb;
    for (int i = 0; i < DEPTH; i++) begin
      tagA[i] <= nA[i];
      tagB[i] <= nB[i];
      tagD[i] <= nD[i];
    end
  end

  always_comb begin
    validVec = vld;
    readyVec = vld & rdyA & rdyB;
    for (int i = 0; i < DEPTH; i++) dstFlat[i*TAG_W +: TAG_W] = tagD[i];
  end

  // R3: a head slot that stays put wakes at the edge ending the broadcast cycle
  p_head_wake_r3: assert property (@(posedge clk) disable iff (rst)
    (liveVec[0] && bcValid[0] && bcTag[TAG_W-1:0] == tagA[0]) |=> rdyA[0]);

  // R8: an insertion never lands on a slot that an existing entry claims
  p_insert_free_r8: assert property (@(posedge clk) disable iff (rst)
    (strb.take0 || strb.take1) |-> !insClash);

endmodule

// File: rtl/segIssueQueue.sv
`timescale 1ns/1ps
module segIssueQueue
  import iqPkg::*;
#(
  parameter int NUM_SEGS = 4,
  parameter int SEG_SIZE = 8,
  parameter int TAG_W    = 7,
  localparam int DEPTH   = NUM_SEGS * SEG_SIZE,
  localparam int POS_W   = $clog2(DEPTH) + 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0]             insValid,
  input  logic [2*TAG_W-1:0]     insSrcA,
  input  logic [2*TAG_W-1:0]     insSrcB,
  input  logic [1:0]             insRdyA,
  input  logic [1:0]             insRdyB,
  input  logic [2*TAG_W-1:0]     insDst,
  input  logic [1:0]             bcValid,
  input  logic [2*TAG_W-1:0]     bcTag,
  input  logic [DEPTH-1:0]       issueMask,
  output logic [DEPTH-1:0]       readyVec,
  output logic [DEPTH-1:0]       validVec,
  output logic [DEPTH*TAG_W-1:0] dstFlat,
  output logic                   full
);

  iqStrobeT         strb;
  logic [DEPTH-1:0] liveVec, moveMask;
  logic [POS_W-1:0] pos0, pos1;

  iqCtl #(.DEPTH(DEPTH), .POS_W(POS_W)) uCtl (
    .clk(clk), .rst(rst), .validVec(validVec), .issueMask(issueMask),
    .insValid(insValid), .strb(strb), .liveVec(liveVec), .moveMask(moveMask),
    .pos0(pos0), .pos1(pos1), .full(full)
  );

  iqData #(.NUM_SEGS(NUM_SEGS), .SEG_SIZE(SEG_SIZE), .TAG_W(TAG_W),
           .DEPTH(DEPTH), .POS_W(POS_W)) uData (
    .clk(clk), .rst(rst), .bcValid(bcValid), .bcTag(bcTag),
    .insSrcA(insSrcA), .insSrcB(insSrcB), .insRdyA(insRdyA), .insRdyB(insRdyB),
    .insDst(insDst), .strb(strb), .liveVec(liveVec), .moveMask(moveMask),
    .pos0(pos0), .pos1(pos1), .validVec(validVec), .readyVec(readyVec),
    .dstFlat(dstFlat)
  );

endmodule

// File: tb/tb_segIssueQueue.sv
`timescale 1ns/1ps
module tb_segIssueQueue;
  localparam int NS = 2;
  localparam int SS = 8;
  localparam int TW = 4;
  localparam int D  = NS * SS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0]      insValid = '0;
  logic [2*TW-1:0] insSrcA = '0, insSrcB = '0, insDst = '0, bcTag = '0;
  logic [1:0]      insRdyA = '0, insRdyB = '0, bcValid = '0;
  logic [D-1:0]    issueMask = '0;
  logic [D-1:0]    readyVec, validVec;
  logic [D*TW-1:0] dstFlat;
  logic            full;

  segIssueQueue #(.NUM_SEGS(NS), .SEG_SIZE(SS), .TAG_W(TW)) dut (
    .clk(clk), .rst(rst), .insValid(insValid), .insSrcA(insSrcA), .insSrcB(insSrcB),
    .insRdyA(insRdyA), .insRdyB(insRdyB), .insDst(insDst), .bcValid(bcValid),
    .bcTag(bcTag), .issueMask(issueMask), .readyVec(readyVec), .validVec(validVec),
    .dstFlat(dstFlat), .full(full)
  );

  always #4 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // arithmetic model of the queue
  bit          mV [D], mRa [D], mRb [D];
  logic [TW-1:0] mA [D], mB [D], mD [D];
  logic [1:0]  msV [NS];
  logic [TW-1:0] msT [NS][2];

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit mhit(int k, logic [TW-1:0] t);
    bit h = 0;
    for (int l = 0; l < 2; l++) if (msV[k][l] && msT[k][l] == t) h = 1;
    return h;
  endfunction

  task automatic modelStep();
    bit live [D]; bit mv [D];
    bit nv [D]; bit nra [D]; bit nrb [D];
    logic [TW-1:0] na [D]; logic [TW-1:0] nb [D]; logic [TW-1:0] nd [D];
    bit wa [D]; bit wb [D];
    bit seen = 0; int hi = -1; bit hiMv = 0; int vhi = -1; int tail;
    bit fullNow, t0, t1; int p0, p1;
    msV[0] = bcValid; msT[0][0] = bcTag[TW-1:0]; msT[0][1] = bcTag[2*TW-1:TW];
    for (int i = 0; i < D; i++) begin
      live[i] = mV[i] && !issueMask[i];
      mv[i] = live[i] && seen;
      if (!live[i]) seen = 1;
      if (live[i]) begin hi = i; hiMv = mv[i]; end
      if (mV[i]) vhi = i;
    end
    fullNow = (vhi >= D - 2);
    tail = (hi < 0) ? 0 : (hiMv ? hi : hi + 1);
    t0 = !fullNow && insValid[0];
    t1 = !fullNow && insValid[1];
    p0 = tail; p1 = tail + (t0 ? 1 : 0);
    for (int i = 0; i < D; i++) begin
      int s = i / SS;
      bit cr = mv[i] && (i % SS == 0) && (i > 0);
      wa[i] = mRa[i] || mhit(s, mA[i]) || (cr && mhit(s - 1, mA[i]));
      wb[i] = mRb[i] || mhit(s, mB[i]) || (cr && mhit(s - 1, mB[i]));
    end
    for (int i = 0; i < D; i++) begin
      nv[i] = 0; nra[i] = 0; nrb[i] = 0; na[i] = 0; nb[i] = 0; nd[i] = 0;
      if (i + 1 < D && mv[i+1]) begin
        nv[i] = 1; nra[i] = wa[i+1]; nrb[i] = wb[i+1]; na[i] = mA[i+1]; nb[i] = mB[i+1]; nd[i] = mD[i+1];
      end else if (live[i] && !mv[i]) begin
        nv[i] = 1; nra[i] = wa[i]; nrb[i] = wb[i]; na[i] = mA[i]; nb[i] = mB[i]; nd[i] = mD[i];
      end else if ((t0 && p0 == i) || (t1 && p1 == i)) begin
        int n = (t0 && p0 == i) ? 0 : 1;
        logic [TW-1:0] a = insSrcA[n*TW +: TW];
        logic [TW-1:0] b = insSrcB[n*TW +: TW];
        bit ra = insRdyA[n], rb = insRdyB[n];
        for (int k = 0; k < NS; k++) begin
          if (mhit(k, a)) ra = 1;
          if (mhit(k, b)) rb = 1;
        end
        nv[i] = 1; nra[i] = ra; nrb[i] = rb; na[i] = a; nb[i] = b; nd[i] = insDst[n*TW +: TW];
      end
    end
    for (int i = 0; i < D; i++) begin
      mV[i] = nv[i]; mRa[i] = nra[i]; mRb[i] = nrb[i]; mA[i] = na[i]; mB[i] = nb[i]; mD[i] = nd[i];
    end
    for (int k = NS - 1; k >= 1; k--) begin
      msV[k] = msV[k-1]; msT[k][0] = msT[k-1][0]; msT[k][1] = msT[k-1][1];
    end
  endtask

  task automatic checkModel();
    logic [D-1:0] eV = '0, eR = '0;
    logic [D*TW-1:0] eD = '0, msk = '0;
    bit vhiFull; int vhi = -1;
    for (int i = 0; i < D; i++) begin
      eV[i] = mV[i];
      eR[i] = mV[i] && mRa[i] && mRb[i];
      if (mV[i]) begin eD[i*TW +: TW] = mD[i]; msk[i*TW +: TW] = '1; vhi = i; end
    end
    vhiFull = (vhi >= D - 2);
    chk(validVec == eV, "R6 valid vector", 64'(validVec), 64'(eV));
    chk(readyVec == eR, "R2 ready vector", 64'(readyVec), 64'(eR));
    chk((dstFlat & msk) == eD, "R8 destination tags", 64'(dstFlat & msk), 64'(eD));
    chk(full == vhiFull, "R9 full flag", 64'(full), 64'(vhiFull));
  endtask

  task automatic clearIns();
    insValid = '0; insSrcA = '0; insSrcB = '0; insRdyA = '0; insRdyB = '0;
    insDst = '0; bcValid = '0; bcTag = '0; issueMask = '0;
  endtask

  task automatic tick();
    modelStep();
    @(posedge clk);
    @(negedge clk);
    clearIns();
    checkModel();
  endtask

  task automatic doReset();
    clearIns();
    rst = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < D; i++) begin mV[i] = 0; mRa[i] = 0; mRb[i] = 0; mA[i] = 0; mB[i] = 0; mD[i] = 0; end
    for (int k = 0; k < NS; k++) begin msV[k] = 0; msT[k][0] = 0; msT[k][1] = 0; end
    chk(validVec == '0, "R1 valid after reset", 64'(validVec), 64'd0);
    chk(readyVec == '0, "R1 ready after reset", 64'(readyVec), 64'd0);
    chk(full == 1'b0, "R1 full after reset", 64'(full), 64'd0);
  endtask

  task automatic setLane(int n, logic [TW-1:0] a, logic [TW-1:0] b, logic ra, logic rb, logic [TW-1:0] d);
    insValid[n] = 1'b1;
    insSrcA[n*TW +: TW] = a; insSrcB[n*TW +: TW] = b;
    insRdyA[n] = ra; insRdyB[n] = rb; insDst[n*TW +: TW] = d;
  endtask

  // fill cnt entries waiting on tag t for source A, source B already available
  task automatic fillWaiting(int cnt, logic [TW-1:0] t);
    for (int i = 0; i < cnt; i += 2) begin
      setLane(0, t, 4'h0, 1'b0, 1'b1, TW'(i));
      if (i + 1 < cnt) setLane(1, t, 4'h0, 1'b0, 1'b1, TW'(i + 1));
      tick();
    end
  endtask

  initial begin : watchdog
    #(8 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : mainSeq
    logic [31:0] rs = 32'h1234_5678;
    @(negedge clk);
    doReset();

    // R3: segment 0 wakes after the broadcast edge, segment 1 one edge later
    fillWaiting(9, 4'h5);
    bcValid = 2'b01; bcTag[TW-1:0] = 4'h5;
    tick();
    chk(readyVec == 16'h00ff, "R3 segment0 wake", 64'(readyVec), 64'h00ff);
    tick();
    chk(readyVec == 16'h01ff, "R3 segment1 wake one cycle later", 64'(readyVec), 64'h01ff);

    // R7: entry crossing from slot 8 to slot 7 while its tag is presented
    doReset();
    fillWaiting(9, 4'h6);
    issueMask = 16'h0001; bcValid = 2'b01; bcTag[TW-1:0] = 4'h6;
    tick();
    chk(validVec == 16'h00ff, "R5 removal and compaction", 64'(validVec), 64'h00ff);
    chk(readyVec == 16'h00ff, "R7 crossing entry woken", 64'(readyVec), 64'h00ff);
    tick();
    chk(readyVec == 16'h00ff, "R7 crossing entry stays woken", 64'(readyVec), 64'h00ff);

    // R4 and R2: lanes, one source woken is not enough
    doReset();
    setLane(0, 4'h3, 4'h9, 1'b0, 1'b0, 4'h1);
    tick();
    bcValid = 2'b10; bcTag[2*TW-1:TW] = 4'h3;
    tick();
    chk(readyVec[0] == 1'b0, "R2 one source only", 64'(readyVec[0]), 64'd0);
    bcValid = 2'b01; bcTag[TW-1:0] = 4'h9;
    tick();
    chk(readyVec[0] == 1'b1, "R4 lane0 wakes source B", 64'(readyVec[0]), 64'd1);
    doReset();
    setLane(0, 4'h3, 4'h9, 1'b0, 1'b0, 4'h1);
    tick();
    bcValid = 2'b11; bcTag = {4'h3, 4'h9};
    tick();
    chk(readyVec[0] == 1'b1, "R4 both lanes same cycle", 64'(readyVec[0]), 64'd1);

    // R1: a tag in flight at reset does not survive it
    bcValid = 2'b01; bcTag[TW-1:0] = 4'h7;
    tick();
    doReset();
    setLane(0, 4'h7, 4'h0, 1'b0, 1'b1, 4'h2);
    tick();
    chk(readyVec[0] == 1'b0, "R1 stale tag cleared", 64'(readyVec[0]), 64'd0);

    // R10: insertion catches a tag presented the previous cycle
    doReset();
    bcValid = 2'b01; bcTag[TW-1:0] = 4'h7;
    tick();
    setLane(0, 4'h7, 4'h0, 1'b0, 1'b1, 4'h2);
    tick();
    chk(readyVec[0] == 1'b1, "R10 insert against in-flight tag", 64'(readyVec[0]), 64'd1);

    // R9: full boundary
    doReset();
    fillWaiting(14, 4'h1);
    chk(full == 1'b0, "R9 not full at 14", 64'(full), 64'd0);
    fillWaiting(2, 4'h1);
    chk(full == 1'b1, "R9 full at 16", 64'(full), 64'd1);
    issueMask = 16'h0001; setLane(0, 4'h1, 4'h1, 1'b1, 1'b1, 4'hc); setLane(1, 4'h1, 4'h1, 1'b1, 1'b1, 4'hd);
    tick();
    chk(validVec == 16'h7fff, "R9 insertion dropped when full", 64'(validVec), 64'h7fff);
    chk(full == 1'b1, "R9 still full at 15", 64'(full), 64'd1);
    issueMask = 16'h0001;
    tick();
    chk(full == 1'b0, "R9 free at 14", 64'(full), 64'd0);

    // R6 and R8: two gaps close over two cycles, lone lane1 goes behind youngest
    doReset();
    for (int i = 0; i < 6; i += 2) begin
      setLane(0, 4'h0, 4'h0, 1'b1, 1'b1, TW'(i));
      setLane(1, 4'h0, 4'h0, 1'b1, 1'b1, TW'(i + 1));
      tick();
    end
    issueMask = 16'h0006;
    tick();
    chk(validVec == 16'h001d, "R6 one step per cycle", 64'(validVec), 64'h001d);
    setLane(1, 4'h0, 4'h0, 1'b1, 1'b1, 4'h9);
    tick();
    chk(validVec == 16'h001f, "R6 gap closed", 64'(validVec), 64'h001f);
    chk(dstFlat[19:0] == 20'h95430, "R8 order and lane1 slot", 64'(dstFlat[19:0]), 64'h95430);

    // random sweep against the model
    doReset();
    for (int c = 0; c < 3000; c++) begin
      logic [31:0] r1, r2, r3;
      rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5; r1 = rs;
      rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5; r2 = rs;
      rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5; r3 = rs;
      insValid = r1[1:0];
      insSrcA = r1[9:2]; insSrcB = r1[17:10]; insDst = r1[25:18];
      insRdyA = r1[27:26] & r1[29:28]; insRdyB = r1[31:30] & r2[1:0];
      bcValid = r2[3:2]; bcTag = r2[11:4];
      issueMask = r2[27:12] & r3[15:0] & r3[31:16];
      tick();
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule